// File: doc/BRIEF.md
# Banked Control Register File

This block holds the processor control state: the status word (a live status byte, a backup status byte and a separate condition bit), a second-level backup status byte, interrupt and user stack-pointer slots, backup and second-level backup program counters, and spare 32-bit registers. Software reaches it through one indexed write port and one indexed read port. The read port is registered.

The stack pointer that the current stack mode selects is not kept here. It lives in general register 15, outside the block. The block sees that register through `sp_rd` and updates it through `sp_we`/`sp_wd`, which act in the same cycle as the control write that causes them. When a status-word write flips the stack-mode bit, the block swaps banks in one cycle. The outgoing stack pointer is parked in its slot and the incoming one is loaded into general register 15. Only the stack pointer of the mode that is not active sits in its slot.

Top module: `ctrl_bank_top`

## Requirements
- R1: Reading index 0 (status word) returns the backup status byte AND 0xC1 in bits 15:8, the status byte AND 0xC0 in bits 7:0 with the condition bit ORed into bit 0, and zero in bits 31:16.
- R2: Writing index 0 loads the backup status byte from data bits 15:8, the status byte from bits 7:0 and the condition bit from bit 0.
- R3: Bit 7 of the status byte is the stack mode (1 = system, 0 = user) and follows the last status-word write.
- R4: A status-word write that changes the mode from user to system saves `sp_rd` into the user slot and drives `sp_we`=1 with `sp_wd` equal to the interrupt slot in the same cycle.
- R5: A status-word write that changes the mode from system to user saves `sp_rd` into the interrupt slot and drives `sp_wd` equal to the user slot with `sp_we`=1. A status-word write that keeps the mode leaves both slots and general register 15 untouched.
- R6: Index 2 (interrupt stack pointer) in system mode reads `sp_rd` and writes through `sp_we`/`sp_wd`. In user mode it reads and writes the interrupt slot.
- R7: Index 3 (user stack pointer) in user mode reads `sp_rd` and writes through `sp_we`/`sp_wd`. In system mode it reads and writes the user slot.
- R8: Index 6 (backup PC) and index 14 (second-level backup PC) store all 32 written bits and read back with bit 0 forced to 0.
- R9: Index 8 (second-level backup status) stores data bits 7:0 and reads back that byte AND 0xC1 in bits 7:0, with zero above.
- R10: Writing index 1 changes only the condition bit, taken from data bit 0. Reading index 1 returns the condition bit in bit 0 and zero elsewhere.
- R11: Indices 4 and 5 are plain 32-bit read/write registers.
- R12: Indices 7, 9 to 13 and 15 read as zero. Writes to them change no register and do not assert `sp_we`.
- R13: `rd_data` shows the register selected by `rd_idx` one clock later, with the state from before any write that takes effect at that same edge.
- R14: Synchronous reset clears every register and `rd_data`, which leaves the block in user mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_idx | input | 4 | Control register write index |
| wr_data | input | 32 | Control register write data |
| rd_idx | input | 4 | Control register read index |
| rd_data | output | 32 | Registered read data |
| sp_rd | input | 32 | Current value of general register 15 |
| sp_we | output | 1 | Write strobe for general register 15 |
| sp_wd | output | 32 | Write data for general register 15 |

## Verification
Random status-word writes carry random stack-mode bits, so the bench sees mode-preserving writes next to both swap directions. A wrong or missing bank exchange shows up as a mismatch on general register 15 or on a later stack-pointer read. The stack-pointer indices are read and written in both modes, while an outside writer changes general register 15 in between. That separates a correct live access from one served from a stale slot. Directed cases cover the all-ones patterns that expose the status and backup masks and the PC bit-0 clearing, writes to unmapped indices followed by full readback, and a read of a register in the same cycle as a write to it.

// File: rtl/ctrl_bank_pkg.sv
package ctrl_bank_pkg;
  localparam int IDX_W = 4;
  typedef logic [IDX_W-1:0] cr_idx_t;

  // Index encodings seen by software
  localparam cr_idx_t CR_PSW    = 4'd0;
  localparam cr_idx_t CR_COND   = 4'd1;
  localparam cr_idx_t CR_ISP    = 4'd2;
  localparam cr_idx_t CR_USP    = 4'd3;
  localparam cr_idx_t CR_SPARE0 = 4'd4;
  localparam cr_idx_t CR_BPC    = 4'd6;
  localparam cr_idx_t CR_BBPSW  = 4'd8;
  localparam cr_idx_t CR_BBPC   = 4'd14;

  localparam logic [7:0] BK_MASK = 8'hC1;
  localparam logic [7:0] ST_MASK = 8'hC0;
  localparam int SM_BIT = 7;

  typedef struct packed {
    logic psw;
    logic cond;
    logic isp;
    logic usp;
    logic bpc;
    logic bbpsw;
    logic bbpc;
  } cr_wstb_t;
endpackage

// File: rtl/ctrl_wr_decode.sv
module ctrl_wr_decode
  import ctrl_bank_pkg::*;
#(
  parameter int SPARE_N = 2
) (
  input  logic               wr_en,
  input  cr_idx_t            wr_idx,
  output cr_wstb_t           stb,
  output logic [SPARE_N-1:0] spare_stb
);
  always_comb begin
    stb       = '0;
    stb.psw   = wr_en && (wr_idx == CR_PSW);
    stb.cond  = wr_en && (wr_idx == CR_COND);
    stb.isp   = wr_en && (wr_idx == CR_ISP);
    stb.usp   = wr_en && (wr_idx == CR_USP);
    stb.bpc   = wr_en && (wr_idx == CR_BPC);
    stb.bbpsw = wr_en && (wr_idx == CR_BBPSW);
    stb.bbpc  = wr_en && (wr_idx == CR_BBPC);
  end

  for (genvar i = 0; i < SPARE_N; i++) begin : g_spare_dec
    assign spare_stb[i] = wr_en && (int'(wr_idx) == int'(CR_SPARE0) + i);
  end
endmodule

// File: rtl/ctrl_status_unit.sv
module ctrl_status_unit
  import ctrl_bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_psw,
  input  logic              we_cond,
  input  logic              we_bbpsw,
  input  logic [15:0]       wdat,
  output logic              sm,
  output logic [DATA_W-1:0] psw_view,
  output logic [DATA_W-1:0] cond_view,
  output logic [DATA_W-1:0] bbpsw_view
);
  logic [7:0] psw_q;
  logic [7:0] bpsw_q;
  logic [7:0] bbpsw_q;
  logic       cond_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      psw_q   <= '0;
      bpsw_q  <= '0;
      bbpsw_q <= '0;
      cond_q  <= 1'b0;
    end else begin
      if (we_psw) begin
        psw_q  <= wdat[7:0];
        bpsw_q <= wdat[15:8];
        cond_q <= wdat[0];
      end
      if (we_cond)  cond_q  <= wdat[0];
      if (we_bbpsw) bbpsw_q <= wdat[7:0];
    end
  end

  assign sm = psw_q[SM_BIT];

  always_comb begin
    psw_view        = '0;
    psw_view[15:8]  = bpsw_q & BK_MASK;
    psw_view[7:0]   = (psw_q & ST_MASK) | {7'd0, cond_q};
    cond_view       = '0;
    cond_view[0]    = cond_q;
    bbpsw_view      = '0;
    bbpsw_view[7:0] = bbpsw_q & BK_MASK;
  end
endmodule

// File: rtl/ctrl_stack_bank.sv
module ctrl_stack_bank #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sm,
  input  logic              we_psw,
  input  logic              new_sm,
  input  logic              we_isp,
  input  logic              we_usp,
  input  logic [DATA_W-1:0] wdat,
  input  logic [DATA_W-1:0] sp_rd,
  output logic              sp_we,
  output logic [DATA_W-1:0] sp_wd,
  output logic [DATA_W-1:0] isp_view,
  output logic [DATA_W-1:0] usp_view
);
  logic [DATA_W-1:0] isp_q;
  logic [DATA_W-1:0] usp_q;
  logic enter_sys;
  logic leave_sys;

  assign enter_sys = we_psw && !sm && new_sm;
  assign leave_sys = we_psw && sm && !new_sm;

  always_comb begin
    sp_we = 1'b0;
    sp_wd = wdat;
    if (enter_sys) begin
      sp_we = 1'b1;
      sp_wd = isp_q;
    end else if (leave_sys) begin
      sp_we = 1'b1;
      sp_wd = usp_q;
    end else if ((we_isp && sm) || (we_usp && !sm)) begin
      sp_we = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isp_q <= '0;
      usp_q <= '0;
    end else begin
      if (enter_sys)          usp_q <= sp_rd;
      else if (we_usp && sm)  usp_q <= wdat;
      if (leave_sys)          isp_q <= sp_rd;
      else if (we_isp && !sm) isp_q <= wdat;
    end
  end

  assign isp_view = sm ? sp_rd : isp_q;
  assign usp_view = sm ? usp_q : sp_rd;
endmodule

// File: rtl/ctrl_misc_regs.sv
module ctrl_misc_regs #(
  parameter int DATA_W  = 32,
  parameter int SPARE_N = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           we_bpc,
  input  logic                           we_bbpc,
  input  logic [SPARE_N-1:0]             we_spare,
  input  logic [DATA_W-1:0]              wdat,
  output logic [DATA_W-1:0]              bpc_view,
  output logic [DATA_W-1:0]              bbpc_view,
  output logic [SPARE_N-1:0][DATA_W-1:0] spare_view
);
  localparam logic [DATA_W-1:0] PC_MASK = ~(DATA_W'(1));

  logic [DATA_W-1:0] bpc_q;
  logic [DATA_W-1:0] bbpc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bpc_q  <= '0;
      bbpc_q <= '0;
    end else begin
      if (we_bpc)  bpc_q  <= wdat;
      if (we_bbpc) bbpc_q <= wdat;
    end
  end

  assign bpc_view  = bpc_q & PC_MASK;
  assign bbpc_view = bbpc_q & PC_MASK;

  for (genvar i = 0; i < SPARE_N; i++) begin : g_spare
    logic [DATA_W-1:0] sp_q;
    always_ff @(posedge clk) begin
      if (rst)              sp_q <= '0;
      else if (we_spare[i]) sp_q <= wdat;
    end
    assign spare_view[i] = sp_q;
  end
endmodule

// File: rtl/ctrl_bank_top.sv
module ctrl_bank_top
  import ctrl_bank_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SPARE_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [3:0]        rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] sp_rd,
  output logic              sp_we,
  output logic [DATA_W-1:0] sp_wd
);
  cr_wstb_t                      stb;
  logic [SPARE_N-1:0]            spare_stb;
  logic                          stk_mode;
  logic [DATA_W-1:0]             psw_view, cond_view, bbpsw_view;
  logic [DATA_W-1:0]             isp_view, usp_view;
  logic [DATA_W-1:0]             bpc_view, bbpc_view;
  logic [SPARE_N-1:0][DATA_W-1:0] spare_view;
  logic [DATA_W-1:0]             rd_next;

  ctrl_wr_decode #(.SPARE_N(SPARE_N)) u_dec (
    .wr_en(wr_en), .wr_idx(wr_idx), .stb(stb), .spare_stb(spare_stb)
  );

  ctrl_status_unit #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst(rst),
    .we_psw(stb.psw), .we_cond(stb.cond), .we_bbpsw(stb.bbpsw),
    .wdat(wr_data[15:0]), .sm(stk_mode),
    .psw_view(psw_view), .cond_view(cond_view), .bbpsw_view(bbpsw_view)
  );

  ctrl_stack_bank #(.DATA_W(DATA_W)) u_stack (
    .clk(clk), .rst(rst), .sm(stk_mode),
    .we_psw(stb.psw), .new_sm(wr_data[SM_BIT]),
    .we_isp(stb.isp), .we_usp(stb.usp), .wdat(wr_data),
    .sp_rd(sp_rd), .sp_we(sp_we), .sp_wd(sp_wd),
    .isp_view(isp_view), .usp_view(usp_view)
  );

  ctrl_misc_regs #(.DATA_W(DATA_W), .SPARE_N(SPARE_N)) u_misc (
    .clk(clk), .rst(rst),
    .we_bpc(stb.bpc), .we_bbpc(stb.bbpc), .we_spare(spare_stb),
    .wdat(wr_data),
    .bpc_view(bpc_view), .bbpc_view(bbpc_view), .spare_view(spare_view)
  );

  always_comb begin
    rd_next = '0;
    case (rd_idx)
      CR_PSW:   rd_next = psw_view;
      CR_COND:  rd_next = cond_view;
      CR_ISP:   rd_next = isp_view;
      CR_USP:   rd_next = usp_view;
      CR_BPC:   rd_next = bpc_view;
      CR_BBPSW: rd_next = bbpsw_view;
      CR_BBPC:  rd_next = bbpc_view;
      default:  rd_next = '0;
    endcase
    for (int i = 0; i < SPARE_N; i++) begin
      if (int'(rd_idx) == int'(CR_SPARE0) + i) rd_next = spare_view[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/ctrl_bank_chk.sv
module ctrl_bank_chk
  import ctrl_bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic              wr_sm,
  input logic [3:0]        rd_idx,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] sp_rd,
  input logic              sp_we,
  input logic              sm
);
  function automatic logic unmapped(input logic [3:0] idx);
    return idx == 4'd7 || (idx >= 4'd9 && idx <= 4'd13) || idx == 4'd15;
  endfunction

  // R3: mode follows the status-word write
  a_r3_mode_tracks: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == CR_PSW) |=> (sm == $past(wr_sm)));

  // R4: entering system mode drives general register 15
  a_r4_enter_swap: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == CR_PSW && !sm && wr_sm) |-> sp_we);

  // R5: leaving system mode drives general register 15
  a_r5_leave_swap: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == CR_PSW && sm && !wr_sm) |-> sp_we);

  // R5: a status write that keeps the mode leaves the stack pointer alone
  a_r5_same_mode_quiet: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == CR_PSW && sm == wr_sm) |-> !sp_we);

  // R6: interrupt stack pointer is live in system mode
  a_r6_isp_live: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && rd_idx == CR_ISP && sm) |=> (rd_data == $past(sp_rd)));

  // R7: user stack pointer is live in user mode
  a_r7_usp_live: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && rd_idx == CR_USP && !sm) |=> (rd_data == $past(sp_rd)));

  // R8: backup PCs read even
  a_r8_pc_even: assert property (@(posedge clk) disable iff (rst)
    (rd_idx == CR_BPC || rd_idx == CR_BBPC) |=> !rd_data[0]);

  // R1: status word reserved bits read zero
  a_r1_psw_zero_bits: assert property (@(posedge clk) disable iff (rst)
    (rd_idx == CR_PSW) |=> (rd_data[DATA_W-1:16] == '0 && rd_data[13:9] == '0
                            && rd_data[5:1] == '0));

  // R12: unmapped indices read zero and never touch the stack pointer
  a_r12_unmapped_read: assert property (@(posedge clk) disable iff (rst)
    unmapped(rd_idx) |=> (rd_data == '0));
  a_r12_unmapped_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && unmapped(wr_idx)) |-> !sp_we);

  // R14: read data is zero right after reset
  always @(posedge clk) begin
    if (!rst && $past(rst)) begin
      a_r14_reset_clear: assert (rd_data == '0 && !sm);
    end
  end
endmodule

bind ctrl_bank_top ctrl_bank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
  .wr_sm(wr_data[7]), .rd_idx(rd_idx), .rd_data(rd_data),
  .sp_rd(sp_rd), .sp_we(sp_we), .sm(stk_mode)
);

// File: tb/tb_ctrl_bank_top.sv
`timescale 1ns/1ps
module tb_ctrl_bank_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic [31:0] sp_rd;
  logic        sp_we;
  logic [31:0] sp_wd;

  // general register 15 lives here, outside the block
  logic [31:0] gr15 = '0;
  logic        ext_we = 1'b0;
  logic [31:0] ext_wd = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [7:0]  m_psw, m_bpsw, m_bbpsw;
  logic        m_cond;
  logic [31:0] m_isp, m_usp, m_bpc, m_bbpc, m_sp4, m_sp5, m_gr15;

  always #10 clk = ~clk;

  ctrl_bank_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .sp_rd(sp_rd), .sp_we(sp_we), .sp_wd(sp_wd)
  );

  assign sp_rd = gr15;
  always @(posedge clk) begin
    if (rst)         gr15 <= '0;
    else if (sp_we)  gr15 <= sp_wd;
    else if (ext_we) gr15 <= ext_wd;
  end

  function automatic string tag_of(input logic [3:0] i);
    case (i)
      4'd0: return "R1";
      4'd1: return "R10";
      4'd2: return "R6";
      4'd3: return "R7";
      4'd4, 4'd5: return "R11";
      4'd6, 4'd14: return "R8";
      4'd8: return "R9";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [3:0] i);
    case (i)
      4'd0: return {16'd0, m_bpsw & 8'hC1, (m_psw & 8'hC0) | {7'd0, m_cond}};
      4'd1: return {31'd0, m_cond};
      4'd2: return m_psw[7] ? m_gr15 : m_isp;
      4'd3: return m_psw[7] ? m_usp : m_gr15;
      4'd4: return m_sp4;
      4'd5: return m_sp5;
      4'd6: return m_bpc & ~32'd1;
      4'd8: return {24'd0, m_bbpsw & 8'hC1};
      4'd14: return m_bbpc & ~32'd1;
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_reset();
    m_psw = 0; m_bpsw = 0; m_bbpsw = 0; m_cond = 0;
    m_isp = 0; m_usp = 0; m_bpc = 0; m_bbpc = 0; m_sp4 = 0; m_sp5 = 0; m_gr15 = 0;
  endtask

  task automatic model_write(input logic [3:0] i, input logic [31:0] d, input logic [31:0] g_old);
    logic sm_old;
    sm_old = m_psw[7];
    case (i)
      4'd0: begin
        m_bpsw = d[15:8]; m_psw = d[7:0]; m_cond = d[0];
        if (!sm_old && d[7])      begin m_usp = g_old; m_gr15 = m_isp; end
        else if (sm_old && !d[7]) begin m_isp = g_old; m_gr15 = m_usp; end
      end
      4'd1: m_cond = d[0];
      4'd2: if (sm_old) m_gr15 = d; else m_isp = d;
      4'd3: if (!sm_old) m_gr15 = d; else m_usp = d;
      4'd4: m_sp4 = d;
      4'd5: m_sp5 = d;
      4'd6: m_bpc = d;
      4'd8: m_bbpsw = d[7:0];
      4'd14: m_bbpc = d;
      default: ;
    endcase
  endtask

  task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", t, act, exp);
    end
  endtask

  // one bus cycle: optional control write, a read, optional outside write to gr15
  task automatic step(input logic we, input logic [3:0] wi, input logic [31:0] wd,
                      input logic [3:0] ri, input logic xw, input logic [31:0] xd,
                      input string t);
    logic [31:0] exp;
    logic [31:0] g_old;
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_data = wd; rd_idx = ri; ext_we = xw; ext_wd = xd;
    exp = model_read(ri);
    @(posedge clk);
    g_old = m_gr15;
    if (xw) m_gr15 = xd;
    if (we) model_write(wi, wd, g_old);
    #1;
    chk(rd_data === exp, tag_of(ri), rd_data, exp);
    chk(gr15 === m_gr15, t, gr15, m_gr15);
  endtask

  task automatic rd(input logic [3:0] ri, input string t);
    step(1'b0, 4'd0, 32'd0, ri, 1'b0, 32'd0, t);
  endtask

  task automatic wr(input logic [3:0] wi, input logic [31:0] wd, input string t);
    step(1'b1, wi, wd, 4'd0, 1'b0, 32'd0, t);
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got %h expected %h", 32'd0, 32'd1);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    chk(rd_data === 32'd0, "R14", rd_data, 32'd0);
    for (int i = 0; i < 16; i++) rd(4'(i), "R14");

    // live and banked stack pointers in user mode
    step(1'b0, 4'd0, 32'd0, 4'd3, 1'b1, 32'hA000_0010, "R7");
    wr(4'd2, 32'h1111_0000, "R6");
    rd(4'd2, "R6");
    rd(4'd3, "R7");
    wr(4'd3, 32'h0000_2222, "R7");
    // user -> system
    wr(4'd0, 32'h0000_C181, "R4");
    rd(4'd0, "R2");
    rd(4'd2, "R6");
    rd(4'd3, "R7");
    step(1'b0, 4'd0, 32'd0, 4'd2, 1'b1, 32'h5555_AAAA, "R6");
    rd(4'd2, "R6");
    wr(4'd3, 32'h0000_3333, "R7");
    rd(4'd3, "R7");
    // same mode: no swap
    wr(4'd0, 32'h0000_0080, "R5");
    rd(4'd0, "R3");
    // system -> user
    wr(4'd0, 32'h0000_0000, "R5");
    rd(4'd3, "R5");
    wr(4'd0, 32'h0000_0000, "R5");
    rd(4'd2, "R5");
    // mask patterns
    wr(4'd0, 32'hFFFF_FFFF, "R2");
    rd(4'd0, "R1");
    wr(4'd1, 32'hFFFF_FFFE, "R10");
    rd(4'd0, "R10");
    rd(4'd1, "R10");
    wr(4'd6, 32'hFFFF_FFFF, "R8");
    rd(4'd6, "R8");
    wr(4'd14, 32'h1234_5679, "R8");
    rd(4'd14, "R8");
    wr(4'd8, 32'hFFFF_ABCD, "R9");
    rd(4'd8, "R9");
    wr(4'd4, 32'hDEAD_BEEF, "R11");
    wr(4'd5, 32'hCAFE_F00D, "R11");
    rd(4'd4, "R11");
    rd(4'd5, "R11");
    // unmapped writes ignored
    for (int i = 7; i < 16; i++) if (i != 8 && i != 14) wr(4'(i), 32'hFFFF_FFFF, "R12");
    for (int i = 0; i < 16; i++) rd(4'(i), "R12");
    // read and write of the same register in one cycle returns old value
    step(1'b1, 4'd4, 32'h0BAD_0BAD, 4'd4, 1'b0, 32'd0, "R13");
    rd(4'd4, "R13");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [3:0]  wi, ri;
      logic [31:0] wd, xd;
      logic        we, xw;
      we = ($urandom % 3) != 0;
      case ($urandom % 4)
        0: wi = 4'd0;
        1: wi = 4'($urandom % 4);
        default: wi = 4'($urandom);
      endcase
      wd = $urandom;
      ri = 4'($urandom);
      xw = ($urandom % 4) == 0;
      xd = $urandom;
      step(we, wi, wd, ri, xw, xd, (we && wi == 4'd0) ? "R4" : "R6");
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule